// File: doc/BRIEF.md
# Full-Duplex Byte Serial Controller with Master and Slave Roles

This block moves one byte at a time over a four-wire synchronous serial link. On every transfer it shifts a byte out of its serial data output, most significant bit first, while it shifts a byte in on its serial data input. A single serial clock times both directions. An active-low select line frames each byte. The block can drive the link as master or answer it as slave. A host loads the outgoing byte, reads the incoming byte and watches a few status flags through a plain register-style port.

As master, the block generates the serial clock from the system clock. The clock toggles every `half_div + 1` system cycles, so the division ratio is always even. The select output stays low for the whole frame. The master works only with clock phase 0, with either idle polarity. The phase input has no effect in this role. As slave, the block brings the external clock and select into its own clock domain through synchronizers. It accepts every combination of polarity and phase.

The outgoing path has one buffer, which is the shift register itself. For this reason the host may not write while a byte is in flight. The incoming path has two buffers: a shift register and a read-data register behind it. The host can therefore read one byte while the next one arrives.

Top module: `spi_duplex_ctl`

## Requirements
- R1: As master, a write accepted while idle starts a frame. `ss_n_o` is low for exactly 2·DATA_W·(half_div+1) system cycles. `sclk_o` makes 2·DATA_W transitions, the first one half_div+1 cycles after the select falls.
- R2: As master, the link always uses phase 0 and the `cpha` input is ignored. `sdo` carries bit DATA_W-1 of the written byte from the cycle the select falls. It changes only on trailing clock edges and sends the bits MSB first. `sdi` is sampled on leading edges.
- R3: `sclk_o` rests at the level of `cpol` whenever `ss_n_o` is high. A leading edge is the transition away from `cpol`; a trailing edge is the transition back to it.
- R4: As slave, the block accepts all four modes. With `cpha`=0 it presents the MSB on `sdo` while selected and before the first edge, samples on leading edges and moves to the next bit on trailing edges. With `cpha`=1 it moves to the next bit on every leading edge except the first of a byte, and samples on trailing edges.
- R5: When the last bit of a byte is sampled, the byte received MSB first is copied into `rd_data` and `rx_full` is set. This happens in both roles.
- R6: If a byte completes while `rx_full` is set and no read happens in the same cycle, `overrun` is set. `rd_data` then keeps the older byte.
- R7: A pulse on `rd_en` clears `rx_full`.
- R8: A write while `busy` is high is rejected and sets the sticky flag `wcol`. The byte being sent is not changed. `busy` is high during a master frame, and in slave role while the synchronized select is low.
- R9: As slave, if the select rises before a byte is complete, the bits already taken are discarded. `rx_full` is not set, and the next frame starts counting from its first bit.
- R10: A pulse on `flag_clr` clears `wcol` and `overrun`.
- R11: After reset `rx_full`, `overrun`, `wcol` and `busy` are 0, and `ss_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | 1 selects master role, 0 selects slave role |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Clock phase, used in slave role only |
| half_div | input | DIV_W | Serial clock half period in system cycles, minus one |
| wr_en | input | 1 | Write strobe for the outgoing byte |
| wr_data | input | DATA_W | Outgoing byte |
| rd_en | input | 1 | Read strobe, clears the receive-full flag |
| flag_clr | input | 1 | Clears the collision and overrun flags |
| rd_data | output | DATA_W | Last byte accepted into the read-data register |
| rx_full | output | 1 | Read-data register holds an unread byte |
| overrun | output | 1 | Sticky flag: a byte arrived while the previous one was unread |
| wcol | output | 1 | Sticky flag: a write arrived during a transfer |
| busy | output | 1 | Transfer in progress |
| sclk_o | output | 1 | Serial clock driven in master role |
| ss_n_o | output | 1 | Active-low select driven in master role |
| sclk_i | input | 1 | Serial clock received in slave role |
| ss_n_i | input | 1 | Active-low select received in slave role |
| sdo | output | 1 | Serial data out (master out in master role, slave out in slave role) |
| sdi | input | 1 | Serial data in |

## Verification
The bench builds the block with DATA_W=8, DIV_W=4 and SYNC_STAGES=2. The narrow divider field keeps master frames short, and it still reaches the fastest ratio (half_div=0, a clock toggle every system cycle) as well as slower settings up to half_div=3. With two synchronizer stages, a slave clock with a half period of eight system cycles leaves enough margin to test all four slave modes. It also allows aborting a frame mid-byte and loading back-to-back bytes to force an overrun.

// File: rtl/spi_duplex_pkg.sv
package spi_duplex_pkg;

   // Per-cycle events that a role engine hands to the shared datapath
   typedef struct packed {
      logic busy;    // transfer in progress for this role
      logic sample;  // take sdi into the receive shifter this cycle
      logic shift;   // move the transmit shifter to the next bit
      logic done;    // this sample completes a byte
   } xfer_evt_t;

endpackage

// File: rtl/spi_bit_sync.sv
module spi_bit_sync #(
   parameter int                 WIDTH   = 1,
   parameter int                 STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_bit_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_mst_clkgen.sv
module spi_mst_clkgen
   import spi_duplex_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cpol,
   input  logic [DIV_W-1:0] half_div,
   output logic             sclk,
   output logic             ss_n,
   output xfer_evt_t        evt
);

   localparam int            EW     = $clog2(2*DATA_W);
   localparam logic [EW-1:0] LAST_E = EW'(2*DATA_W-1);
   localparam logic [EW-1:0] LAST_S = EW'(2*DATA_W-2);

   logic             active;
   logic [DIV_W-1:0] div_cnt;
   logic [EW-1:0]    edge_cnt;
   logic             sclk_q;
   logic             tick;

   assign tick = active && (div_cnt == half_div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         div_cnt  <= '0;
         edge_cnt <= '0;
         sclk_q   <= 1'b0;
      end else if (!active) begin
         sclk_q   <= cpol;
         div_cnt  <= '0;
         edge_cnt <= '0;
         if (start) active <= 1'b1;
      end else if (tick) begin
         div_cnt  <= '0;
         sclk_q   <= ~sclk_q;
         edge_cnt <= edge_cnt + EW'(1);
         if (edge_cnt == LAST_E) active <= 1'b0;
      end else begin
         div_cnt <= div_cnt + DIV_W'(1);
      end
   end

   // even edge index = leading edge (sample), odd = trailing (launch)
   assign evt.busy   = active;
   assign evt.sample = tick && !edge_cnt[0];
   assign evt.shift  = tick && edge_cnt[0] && (edge_cnt != LAST_E);
   assign evt.done   = tick && (edge_cnt == LAST_S);

   assign sclk = active ? sclk_q : cpol;
   assign ss_n = !active;

   // R1
   frame_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> ($past(edge_cnt) == LAST_E));

endmodule

// File: rtl/spi_slv_engine.sv
module spi_slv_engine
   import spi_duplex_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cpol,
   input  logic      cpha,
   input  logic      sclk_i,
   input  logic      ss_n_i,
   output xfer_evt_t evt
);

   localparam int            BW     = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [BW-1:0] LAST_B = BW'(DATA_W-1);

   logic [1:0]    sync_q;
   logic          s_ss_n;
   logic          s_sclk;
   logic          prev_sclk;
   logic          selected;
   logic          sclk_edge;
   logic          lead_edge;
   logic          trail_edge;
   logic          smp;
   logic          lch;
   logic [BW-1:0] bit_cnt;

   spi_bit_sync #(
      .WIDTH   (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (2'b10)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ss_n_i, sclk_i}),
      .q     (sync_q)
   );

   assign s_ss_n = sync_q[1];
   assign s_sclk = sync_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_sclk <= 1'b0;
      else        prev_sclk <= s_sclk;
   end

   assign selected   = !s_ss_n;
   assign sclk_edge  = s_sclk ^ prev_sclk;
   assign lead_edge  = sclk_edge && (s_sclk != cpol);
   assign trail_edge = sclk_edge && (s_sclk == cpol);
   assign smp        = selected && (cpha ? trail_edge : lead_edge);
   assign lch        = selected && (cpha ? lead_edge : trail_edge);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
      end else if (!selected) begin
         bit_cnt <= '0;
      end else if (smp) begin
         bit_cnt <= (bit_cnt == LAST_B) ? '0 : bit_cnt + BW'(1);
      end
   end

   // phase 1: first leading edge of a byte only presents the MSB already on sdo
   assign evt.busy   = selected;
   assign evt.sample = smp;
   assign evt.done   = smp && (bit_cnt == LAST_B);
   assign evt.shift  = lch && !(cpha && (bit_cnt == '0));

   // R9
   abort_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(s_ss_n) |=> (bit_cnt == '0));

endmodule

// File: rtl/spi_rx_hold.sv
module spi_rx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              rd_en,
   input  logic              clr,
   output logic [DATA_W-1:0] rd_data,
   output logic              full,
   output logic              overrun
);

   logic accept;
   logic lost;

   assign lost   = load && full && !rd_en;
   assign accept = load && !lost;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         full    <= 1'b0;
         overrun <= 1'b0;
      end else begin
         if (lost)      overrun <= 1'b1;
         else if (clr)  overrun <= 1'b0;

         if (accept) begin
            rd_data <= load_data;
            full    <= 1'b1;
         end else if (rd_en) begin
            full <= 1'b0;
         end
      end
   end

   // R6
   keep_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && full && !rd_en) |=> (overrun && $stable(rd_data)));

   // R7
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !load) |=> !full);

endmodule

// File: rtl/spi_duplex_ctl.sv
module spi_duplex_ctl
   import spi_duplex_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              is_master,
   input  logic              cpol,
   input  logic              cpha,
   input  logic [DIV_W-1:0]  half_div,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              flag_clr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rx_full,
   output logic              overrun,
   output logic              wcol,
   output logic              busy,
   output logic              sclk_o,
   output logic              ss_n_o,
   input  logic              sclk_i,
   input  logic              ss_n_i,
   output logic              sdo,
   input  logic              sdi
);

   if (DATA_W < 2) begin : g_bad_width
      $error("spi_duplex_ctl: DATA_W must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("spi_duplex_ctl: DIV_W must be at least 1");
   end

   xfer_evt_t         m_evt;
   xfer_evt_t         s_evt;
   xfer_evt_t         evt;
   logic [DATA_W-1:0] tx_sr;
   logic [DATA_W-1:0] rx_sr;
   logic [DATA_W-1:0] rx_next;
   logic              accept_wr;

   assign evt       = is_master ? m_evt : s_evt;
   assign busy      = evt.busy;
   assign accept_wr = wr_en && !evt.busy;

   spi_mst_clkgen #(
      .DATA_W (DATA_W),
      .DIV_W  (DIV_W)
   ) u_mst (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept_wr && is_master),
      .cpol     (cpol),
      .half_div (half_div),
      .sclk     (sclk_o),
      .ss_n     (ss_n_o),
      .evt      (m_evt)
   );

   spi_slv_engine #(
      .DATA_W      (DATA_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_slv (
      .clk    (clk),
      .rst_n  (rst_n),
      .cpol   (cpol),
      .cpha   (cpha),
      .sclk_i (sclk_i),
      .ss_n_i (ss_n_i),
      .evt    (s_evt)
   );

   // transmit: the shifter is the only buffer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          tx_sr <= '0;
      else if (accept_wr)  tx_sr <= wr_data;
      else if (evt.shift)  tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
   end

   assign sdo     = tx_sr[DATA_W-1];
   assign rx_next = {rx_sr[DATA_W-2:0], sdi};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rx_sr <= '0;
      else if (evt.sample) rx_sr <= rx_next;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                wcol <= 1'b0;
      else if (wr_en && busy)    wcol <= 1'b1;
      else if (flag_clr)         wcol <= 1'b0;
   end

   spi_rx_hold #(
      .DATA_W (DATA_W)
   ) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (evt.done),
      .load_data (rx_next),
      .rd_en     (rd_en),
      .clr       (flag_clr),
      .rd_data   (rd_data),
      .full      (rx_full),
      .overrun   (overrun)
   );

   // R8
   wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> wcol);

   // R2
   mst_sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_master && $past(is_master) && !ss_n_o && !$past(ss_n_o) && !$past(m_evt.shift))
         |-> $stable(sdo));

endmodule

// File: tb/spi_duplex_ctl_tb_top.sv
module spi_duplex_ctl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       is_master = 1'b1;
   logic       cpol = 1'b0;
   logic       cpha = 1'b0;
   logic [3:0] half_div = 4'd0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_en = 1'b0;
   logic       flag_clr = 1'b0;
   logic [7:0] rd_data;
   logic       rx_full;
   logic       overrun;
   logic       wcol;
   logic       busy;
   logic       sclk_o;
   logic       ss_n_o;
   logic       sclk_i = 1'b0;
   logic       ss_n_i = 1'b1;
   logic       sdo;
   logic       sdi = 1'b0;

   int  cyc = 0;
   int  n_chk = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   spi_duplex_ctl #(
      .DATA_W      (8),
      .DIV_W       (4),
      .SYNC_STAGES (2)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .is_master (is_master),
      .cpol      (cpol),
      .cpha      (cpha),
      .half_div  (half_div),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .rd_en     (rd_en),
      .flag_clr  (flag_clr),
      .rd_data   (rd_data),
      .rx_full   (rx_full),
      .overrun   (overrun),
      .wcol      (wcol),
      .busy      (busy),
      .sclk_o    (sclk_o),
      .ss_n_o    (ss_n_o),
      .sclk_i    (sclk_i),
      .ss_n_i    (ss_n_i),
      .sdo       (sdo),
      .sdi       (sdi)
   );

   // fields: [22] master, [21] cpol, [20] cpha, [19:16] half_div, [15:8] tx byte, [7:0] peer byte
   localparam logic [22:0] VECS [0:7] = '{
      {1'b1, 1'b0, 1'b0, 4'd1, 8'hA5, 8'h3C},
      {1'b1, 1'b1, 1'b0, 4'd0, 8'h81, 8'h7E},
      {1'b1, 1'b0, 1'b1, 4'd2, 8'h5A, 8'hC3},
      {1'b1, 1'b1, 1'b1, 4'd3, 8'hFF, 8'h00},
      {1'b0, 1'b0, 1'b0, 4'd0, 8'h96, 8'h69},
      {1'b0, 1'b0, 1'b1, 4'd0, 8'h12, 8'hED},
      {1'b0, 1'b1, 1'b0, 4'd0, 8'hF0, 8'h0F},
      {1'b0, 1'b1, 1'b1, 4'd0, 8'h01, 8'h80}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_read();
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      chk(rx_full == 1'b0, "R7", "rx_full after read", 32'(rx_full), 0);
   endtask

   task automatic pulse_clr();
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
   endtask

   // bench acts as the slave peer of the DUT master
   task automatic master_xfer(input logic pol, input logic pha, input logic [3:0] hd,
                              input logic [7:0] tx, input logic [7:0] peer,
                              input bit chk_rx, input bit inject);
      logic [7:0] got;
      int t0;
      int t1;
      got = 8'h00;
      @(negedge clk);
      is_master = 1'b1; cpol = pol; cpha = pha; half_div = hd; sdi = peer[7];
      @(negedge clk); wr_data = tx; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0; t0 = cyc;
      chk(ss_n_o == 1'b0, "R1", "select low after write", 32'(ss_n_o), 0);
      chk(sdo == tx[7], "R2", "msb before first edge", 32'(sdo), 32'(tx[7]));
      for (int k = 0; k < 16; k++) begin
         @(sclk_o);
         if (k % 2 == 0) begin
            got[7 - k/2] = sdo;
            if (inject && k == 2) begin
               @(negedge clk); wr_data = ~tx; wr_en = 1'b1;
               @(negedge clk); wr_en = 1'b0;
               chk(wcol == 1'b1, "R8", "wcol after busy write", 32'(wcol), 1);
            end
         end else if (k < 15) begin
            sdi = peer[7 - (k+1)/2];
         end
      end
      @(negedge clk);
      while (ss_n_o == 1'b0) @(negedge clk);
      t1 = cyc;
      chk((t1 - t0) == 16*(int'(hd)+1), "R1", "frame length", 32'(t1 - t0), 32'(16*(int'(hd)+1)));
      chk(sclk_o == pol, "R3", "clock idle level", 32'(sclk_o), 32'(pol));
      chk(got == tx, "R2", "bits seen on sdo", 32'(got), 32'(tx));
      if (chk_rx) begin
         chk(rx_full == 1'b1, "R5", "rx_full after master frame", 32'(rx_full), 1);
         chk(rd_data == peer, "R5", "master received byte", 32'(rd_data), 32'(peer));
      end
   endtask

   // bench acts as master of the DUT slave, half period 8 system cycles
   task automatic slave_xfer(input logic pol, input logic pha,
                             input logic [7:0] tx, input logic [7:0] peer,
                             input int nbits, input bit chk_rx);
      logic [7:0] got;
      got = 8'h00;
      @(negedge clk);
      is_master = 1'b0; cpol = pol; cpha = pha; sclk_i = pol; ss_n_i = 1'b1;
      wait_cyc(6);
      @(negedge clk); wr_data = tx; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
      sdi = peer[7]; ss_n_i = 1'b0;
      for (int k = 0; k < nbits; k++) begin
         if (!pha) begin
            wait_cyc(8); got[7-k] = sdo; sclk_i = ~pol;
            wait_cyc(8); sclk_i = pol;
            if (k < 7) sdi = peer[6-k];
         end else begin
            wait_cyc(8); sclk_i = ~pol; sdi = peer[7-k];
            wait_cyc(8); got[7-k] = sdo; sclk_i = pol;
         end
      end
      wait_cyc(8); ss_n_i = 1'b1;
      wait_cyc(6);
      if (nbits == 8) begin
         chk(got == tx, "R4", "slave bits on sdo", 32'(got), 32'(tx));
         if (chk_rx) begin
            chk(rx_full == 1'b1, "R5", "rx_full after slave frame", 32'(rx_full), 1);
            chk(rd_data == peer, "R5", "slave received byte", 32'(rd_data), 32'(peer));
         end
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got hung run expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(rx_full == 1'b0, "R11", "rx_full at reset", 32'(rx_full), 0);
      chk(overrun == 1'b0, "R11", "overrun at reset", 32'(overrun), 0);
      chk(wcol == 1'b0, "R11", "wcol at reset", 32'(wcol), 0);
      chk(busy == 1'b0, "R11", "busy at reset", 32'(busy), 0);
      chk(ss_n_o == 1'b1, "R11", "select at reset", 32'(ss_n_o), 1);
      chk(sclk_o == cpol, "R3", "clock idle after reset", 32'(sclk_o), 32'(cpol));

      // table walk: master vectors cover R1 R2 R3, slave vectors cover R4 R5
      for (int i = 0; i < 8; i++) begin
         logic [22:0] v;
         v = VECS[i];
         if (v[22]) master_xfer(v[21], v[20], v[19:16], v[15:8], v[7:0], 1'b1, 1'b0);
         else       slave_xfer(v[21], v[20], v[15:8], v[7:0], 8, 1'b1);
         do_read();
      end

      // R8 write collision, R10 clear
      master_xfer(1'b0, 1'b0, 4'd3, 8'hC6, 8'h5B, 1'b1, 1'b1);
      chk(wcol == 1'b1, "R8", "wcol sticky after frame", 32'(wcol), 1);
      pulse_clr();
      chk(wcol == 1'b0, "R10", "wcol after clear", 32'(wcol), 0);
      do_read();

      // R6 overrun keeps the older byte
      master_xfer(1'b1, 1'b0, 4'd0, 8'h11, 8'h22, 1'b1, 1'b0);
      master_xfer(1'b1, 1'b0, 4'd0, 8'h33, 8'h44, 1'b0, 1'b0);
      chk(overrun == 1'b1, "R6", "overrun set", 32'(overrun), 1);
      chk(rd_data == 8'h22, "R6", "older byte kept", 32'(rd_data), 32'h22);
      pulse_clr();
      chk(overrun == 1'b0, "R10", "overrun after clear", 32'(overrun), 0);
      do_read();
      chk(rd_data == 8'h22, "R6", "read data after overrun", 32'(rd_data), 32'h22);

      // R9 partial byte discarded, next frame restarts
      slave_xfer(1'b0, 1'b1, 8'hAA, 8'h55, 3, 1'b0);
      chk(rx_full == 1'b0, "R9", "rx_full after aborted byte", 32'(rx_full), 0);
      slave_xfer(1'b0, 1'b1, 8'h3C, 8'hC3, 8, 1'b1);
      do_read();
      slave_xfer(1'b1, 1'b0, 8'h00, 8'hFF, 5, 1'b0);
      chk(rx_full == 1'b0, "R9", "rx_full after aborted mode-0 byte", 32'(rx_full), 0);
      slave_xfer(1'b1, 1'b0, 8'hE7, 8'h18, 8, 1'b1);
      do_read();

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule